// File: doc/BRIEF.md
# Framed SPI Command Decoder for Register and Word Memory Access

This block is a serial slave that runs in the system clock domain. It takes a serial clock, a data input and an active-low select from an external master. The serial format is clock idle low, data sampled on the rising edge, most significant bit first. The block groups the bits into bytes and reads each frame as a command. A frame either reaches a small byte-wide register file or a 16-bit word memory. For a read, the block returns data on its serial output at a fixed byte position inside the frame.

A frame opens with an opcode byte. The next byte must be the bitwise complement of that opcode, which guards against corrupted headers. Four opcodes are valid. A register write takes four bytes and a register read takes five. A memory write takes eight bytes and a memory read takes ten. Memory frames carry a 16-bit address and a 16-bit length field. Address bit 15 must be set to select the memory. The length field is accepted and then ignored, because each access moves exactly one word. The rest of the chip can look at any register or memory word through combinational peek ports.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Bits are sampled on rising serial-clock edges while select is low, most significant bit first, eight edges per byte. The serial output changes only after rising edges and is stable before the next one.
- R2: A frame is accepted only when byte 1 equals the bitwise inverse of byte 0 and byte 0 is one of 0x09, 0x08, 0x05 or 0x04. Otherwise the frame writes nothing and the serial output stays 0 for every byte.
- R3: Opcode 0x09 is a register write: byte 2 is the address and byte 3 the data. The register at (address modulo REG_COUNT) takes the data once byte 3 is complete.
- R4: Opcode 0x08 is a register read: byte 2 is the address and byte 3 a don't-care. The addressed register value is shifted out during byte 4, and every other byte returns 0x00.
- R5: Opcode 0x05 is a memory write. Bytes 2–3 hold the address, bytes 4–5 the length and bytes 6–7 the data, each high byte first. The word at (address[14:0] modulo depth) takes the data after byte 7, but only when address bit 15 is 1.
- R6: Opcode 0x04 is a memory read, with the same address and length layout. The addressed word is returned high byte in byte 6 and low byte in byte 7. Bytes 8 and 9 and all earlier bytes return 0x00, and all bytes return 0x00 when address bit 15 is 0.
- R7: Raising select at any point ends the frame. A write whose final byte has not fully arrived has no effect, and the next frame starts again from byte 0.
- R8: After reset every register reads 0x00 and the serial output is 0.
- R9: The memory length field has no effect on either memory write or memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from master (asynchronous) |
| mosi | input | 1 | Serial data from master |
| csN | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to master |
| regPeekAddr | input | REG_AW (4) | Register file peek address |
| regPeekData | output | 8 | Register value at regPeekAddr |
| ramPeekAddr | input | RAM_AW (10) | Memory peek word index |
| ramPeekData | output | 16 | Memory word at ramPeekAddr |

## Verification
The serial inputs pass through two synchronizer flops and an edge-detect flop. A rising serial edge therefore acts on state three system cycles later, and the serial output and the peek ports follow one cycle after that. The bench holds each serial clock phase for four system cycles. It samples the serial output one cycle before each rising edge, when the bit is at least four cycles old. It reads the peek ports only after select has been high for several cycles, well after the final commit. With a 16-entry register file and a 1024-word memory, the bench can sweep every register address, the memory edges and the wrapped aliases in a single run.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

  localparam logic [7:0] OP_REG_WR = 8'h09;
  localparam logic [7:0] OP_REG_RD = 8'h08;
  localparam logic [7:0] OP_RAM_WR = 8'h05;
  localparam logic [7:0] OP_RAM_RD = 8'h04;

  typedef enum logic [1:0] {
    TX_ZERO   = 2'd0,
    TX_REG    = 2'd1,
    TX_RAM_HI = 2'd2,
    TX_RAM_LO = 2'd3
  } txSel_e;

  // strobes from control to datapath, all qualified by a completed byte
  typedef struct packed {
    logic   capRegAddr;
    logic   capRamAddr;
    logic   capDataHi;
    logic   regWrite;
    logic   ramWrite;
    txSel_e txSel;
  } dpCtl_t;

  function automatic logic opKnown(input logic [7:0] op);
    return (op == OP_REG_WR) || (op == OP_REG_RD) ||
           (op == OP_RAM_WR) || (op == OP_RAM_RD);
  endfunction

endpackage

// File: rtl/spicmd_ctrl.sv
module spicmd_ctrl
  import spicmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csActive,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  output dpCtl_t     ctl,
  output logic [3:0] frameByte
);

  logic [7:0] opcode;
  logic       hdrOk;
  logic       ramSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameByte <= '0;
      opcode    <= '0;
      hdrOk     <= 1'b0;
      ramSel    <= 1'b0;
    end else if (!csActive) begin
      frameByte <= '0;
      hdrOk     <= 1'b0;
      ramSel    <= 1'b0;
    end else if (byteDone) begin
      if (frameByte != 4'hF) frameByte <= frameByte + 4'd1;
      case (frameByte)
        4'd0: opcode <= rxByte;
        4'd1: hdrOk  <= (rxByte == ~opcode) && opKnown(opcode);
        4'd2: ramSel <= rxByte[7];
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    if (byteDone && hdrOk) begin
      unique case (opcode)
        OP_REG_WR: begin
          ctl.capRegAddr = (frameByte == 4'd2);
          ctl.regWrite   = (frameByte == 4'd3);
        end
        OP_REG_RD: begin
          ctl.capRegAddr = (frameByte == 4'd2);
          if (frameByte == 4'd3) ctl.txSel = TX_REG;
        end
        OP_RAM_WR: begin
          ctl.capRamAddr = (frameByte == 4'd2) || (frameByte == 4'd3);
          ctl.capDataHi  = (frameByte == 4'd6);
          ctl.ramWrite   = (frameByte == 4'd7) && ramSel;
        end
        OP_RAM_RD: begin
          ctl.capRamAddr = (frameByte == 4'd2) || (frameByte == 4'd3);
          if (ramSel && frameByte == 4'd5) ctl.txSel = TX_RAM_HI;
          if (ramSel && frameByte == 4'd6) ctl.txSel = TX_RAM_LO;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spicmd_datapath.sv
module spicmd_datapath
  import spicmd_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              csN,
  input  dpCtl_t            ctl,
  output logic              csActive,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              miso,
  input  logic [REG_AW-1:0] regPeekAddr,
  output logic [7:0]        regPeekData,
  input  logic [RAM_AW-1:0] ramPeekAddr,
  output logic [15:0]       ramPeekData
);

  localparam int REG_COUNT = 1 << REG_AW;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [1:0]        sclkSy, mosiSy, csSy;
  logic              sclkQ;
  logic              sclkRise;
  logic [2:0]        bitCnt;
  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic [7:0]        txNext;
  logic [REG_AW-1:0] regAddr;
  logic [RAM_AW-1:0] ramAddr;
  logic [7:0]        dataHi;
  logic [7:0]        regFile [REG_COUNT];
  logic [15:0]       ram [RAM_DEPTH];
  logic [15:0]       ramRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSy <= '0;
      mosiSy <= '0;
      csSy   <= '1;
      sclkQ  <= 1'b0;
    end else begin
      sclkSy <= {sclkSy[0], sclk};
      mosiSy <= {mosiSy[0], mosi};
      csSy   <= {csSy[0], csN};
      sclkQ  <= sclkSy[1];
    end
  end

  assign csActive = ~csSy[1];
  assign sclkRise = csActive & sclkSy[1] & ~sclkQ;
  assign rxByte   = {rxShift[6:0], mosiSy[1]};
  assign byteDone = sclkRise && (bitCnt == 3'd7);
  assign ramRd    = ram[ramAddr];

  always_comb begin
    unique case (ctl.txSel)
      TX_REG:    txNext = regFile[regAddr];
      TX_RAM_HI: txNext = ramRd[15:8];
      TX_RAM_LO: txNext = ramRd[7:0];
      default:   txNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
    end else if (!csActive) begin
      bitCnt  <= '0;
      txShift <= '0;
    end else if (sclkRise) begin
      bitCnt  <= bitCnt + 3'd1;
      rxShift <= rxByte;
      txShift <= byteDone ? txNext : {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr <= '0;
      ramAddr <= '0;
      dataHi  <= '0;
    end else begin
      if (ctl.capRegAddr) regAddr <= rxByte[REG_AW-1:0];
      if (ctl.capRamAddr) ramAddr <= RAM_AW'({ramAddr, rxByte});
      if (ctl.capDataHi)  dataHi  <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (ctl.regWrite) begin
      regFile[regAddr] <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ramWrite) ram[ramAddr] <= {dataHi, rxByte};
  end

  assign miso        = txShift[7];
  assign regPeekData = regFile[regPeekAddr];
  assign ramPeekData = ram[ramPeekAddr];

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spicmd_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              csN,
  output logic              miso,
  input  logic [REG_AW-1:0] regPeekAddr,
  output logic [7:0]        regPeekData,
  input  logic [RAM_AW-1:0] ramPeekAddr,
  output logic [15:0]       ramPeekData
);

  dpCtl_t     ctl;
  logic       csActive;
  logic       byteDone;
  logic [7:0] rxByte;
  logic [3:0] frameByte;

  spicmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csActive  (csActive),
    .byteDone  (byteDone),
    .rxByte    (rxByte),
    .ctl       (ctl),
    .frameByte (frameByte)
  );

  spicmd_datapath #(.REG_AW(REG_AW), .RAM_AW(RAM_AW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sclk        (sclk),
    .mosi        (mosi),
    .csN         (csN),
    .ctl         (ctl),
    .csActive    (csActive),
    .byteDone    (byteDone),
    .rxByte      (rxByte),
    .miso        (miso),
    .regPeekAddr (regPeekAddr),
    .regPeekData (regPeekData),
    .ramPeekAddr (ramPeekAddr),
    .ramPeekData (ramPeekData)
  );

endmodule

// File: rtl/spi_cmd_decoder_checker.sv
module spi_cmd_decoder_checker
  import spicmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csActive,
  input logic       byteDone,
  input dpCtl_t     ctl,
  input logic [3:0] frameByte,
  input logic       miso
);

  assert_idle_miso_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (miso == 1'b0));

  assert_count_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (frameByte == 4'd0));

  assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.regWrite, ctl.ramWrite}));

  assert_commit_on_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWrite || ctl.ramWrite) |-> byteDone);

  assert_tx_load_on_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.txSel != TX_ZERO) |-> byteDone);

  assert_frame_advance_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && byteDone && $past(csActive) && frameByte != 4'hF) |=>
      (frameByte == $past(frameByte) + 4'd1));

endmodule

bind spi_cmd_decoder spi_cmd_decoder_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csActive  (csActive),
  .byteDone  (byteDone),
  .ctl       (ctl),
  .frameByte (frameByte),
  .miso      (miso)
);

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;

  localparam int REG_AW = 4;
  localparam int RAM_AW = 10;
  localparam int REG_COUNT = 1 << REG_AW;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic csN = 1'b1;
  logic miso;
  logic [REG_AW-1:0] regPeekAddr = '0;
  logic [7:0]        regPeekData;
  logic [RAM_AW-1:0] ramPeekAddr = '0;
  logic [15:0]       ramPeekData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] txb [10];
  logic [7:0] rxb [10];

  always #5 clk = ~clk;

  spi_cmd_decoder #(.REG_AW(REG_AW), .RAM_AW(RAM_AW)) u_spi_cmd_decoder (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso),
    .regPeekAddr(regPeekAddr), .regPeekData(regPeekData),
    .ramPeekAddr(ramPeekAddr), .ramPeekData(ramPeekData)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      waitClk(3);
      rx[i] = miso;
      waitClk(1);
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
    end
  endtask

  // sends the first n bytes of txb, collecting rxb
  task automatic runFrame(input int n);
    logic [7:0] r;
    csN = 1'b0;
    waitClk(4);
    for (int k = 0; k < n; k++) begin
      xferByte(txb[k], r);
      rxb[k] = r;
    end
    waitClk(4);
    csN = 1'b1;
    waitClk(8);
  endtask

  task automatic setHdr(input logic [7:0] op);
    for (int k = 0; k < 10; k++) txb[k] = 8'h00;
    txb[0] = op;
    txb[1] = ~op;
  endtask

  task automatic regWr(input logic [7:0] a, input logic [7:0] d, input int n);
    setHdr(8'h09);
    txb[2] = a;
    txb[3] = d;
    runFrame(n);
  endtask

  task automatic ramWr(input logic [15:0] a, input logic [15:0] len,
                       input logic [15:0] d, input int n);
    setHdr(8'h05);
    txb[2] = a[15:8]; txb[3] = a[7:0];
    txb[4] = len[15:8]; txb[5] = len[7:0];
    txb[6] = d[15:8]; txb[7] = d[7:0];
    runFrame(n);
  endtask

  task automatic ramRd(input logic [15:0] a, input logic [15:0] len);
    setHdr(8'h04);
    txb[2] = a[15:8]; txb[3] = a[7:0];
    txb[4] = len[15:8]; txb[5] = len[7:0];
    runFrame(10);
  endtask

  function automatic logic [7:0] regPat(input int a);
    return 8'((a * 37 + 11) ^ 8'hA5);
  endfunction

  function automatic logic [15:0] ramPat(input int k);
    return 16'((k * 16'h0123) ^ 16'h5A3C);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    logic [15:0] w;
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);

    // R8: reset state
    check(miso == 1'b0, "R8 miso after reset", int'(miso), 0);
    for (int a = 0; a < REG_COUNT; a++) begin
      regPeekAddr = REG_AW'(a);
      #1;
      check(regPeekData == 8'h00, "R8 register reset value", int'(regPeekData), 0);
    end

    // R3: write every register, R1 byte assembly implied
    for (int a = 0; a < REG_COUNT; a++) regWr(8'(a), regPat(a), 4);
    for (int a = 0; a < REG_COUNT; a++) begin
      regPeekAddr = REG_AW'(a);
      #1;
      check(regPeekData == regPat(a), "R3 register write", int'(regPeekData), int'(regPat(a)));
    end

    // R4: read every register through the serial port
    for (int a = 0; a < REG_COUNT; a++) begin
      setHdr(8'h08);
      txb[2] = 8'(a);
      txb[3] = 8'hFF;
      runFrame(5);
      check(rxb[4] == regPat(a), "R4 register read data byte", int'(rxb[4]), int'(regPat(a)));
      check(rxb[0] == 0 && rxb[1] == 0 && rxb[2] == 0 && rxb[3] == 0,
            "R4 register read leading bytes", int'(rxb[3]), 0);
    end

    // R3: address taken modulo register count
    regWr(8'h15, 8'h3C, 4);
    regPeekAddr = 4'h5;
    #1;
    check(regPeekData == 8'h3C, "R3 address modulo", int'(regPeekData), 8'h3C);

    // R2: bad complement byte, write ignored
    setHdr(8'h09);
    txb[1] = 8'hF7;
    txb[2] = 8'h02;
    txb[3] = 8'hEE;
    runFrame(4);
    regPeekAddr = 4'h2;
    #1;
    check(regPeekData == regPat(2), "R2 bad complement ignored", int'(regPeekData), int'(regPat(2)));

    // R2: read with bad complement returns zero
    setHdr(8'h08);
    txb[1] = 8'h00;
    txb[2] = 8'h02;
    runFrame(5);
    check(rxb[4] == 8'h00, "R2 bad complement read zero", int'(rxb[4]), 0);

    // R2: unknown opcode with correct complement ignored
    setHdr(8'h07);
    txb[2] = 8'h04;
    txb[3] = 8'h99;
    runFrame(5);
    regPeekAddr = 4'h4;
    #1;
    check(regPeekData == regPat(4), "R2 unknown opcode ignored", int'(regPeekData), int'(regPat(4)));
    check(rxb[4] == 8'h00 && rxb[3] == 8'h00, "R2 unknown opcode miso zero", int'(rxb[4]), 0);

    // R7: register write aborted after three bytes
    regWr(8'h06, 8'h77, 3);
    regPeekAddr = 4'h6;
    #1;
    check(regPeekData == regPat(6), "R7 aborted register write", int'(regPeekData), int'(regPat(6)));

    // R5/R6: memory writes at edges and spread addresses
    for (int k = 0; k < 24; k++) begin
      int idx;
      idx = (k < 20) ? k * 51 : RAM_DEPTH - 1 - (k - 20);
      ramWr(16'h8000 | 16'(idx), 16'(k), ramPat(k), 8);
      ramPeekAddr = RAM_AW'(idx);
      #1;
      check(ramPeekData == ramPat(k), "R5 memory write", int'(ramPeekData), int'(ramPat(k)));
      ramRd(16'h8000 | 16'(idx), (k % 2 == 1) ? 16'hFFFF : 16'h0001);
      w = {rxb[6], rxb[7]};
      check(w == ramPat(k), "R6 memory read word", int'(w), int'(ramPat(k)));
      check(rxb[8] == 0 && rxb[9] == 0 && rxb[5] == 0 && rxb[0] == 0,
            "R6 memory read filler bytes", int'(rxb[8]), 0);
    end

    // R5: address wraps modulo depth
    ramWr(16'h8000 | 16'(RAM_DEPTH + 7), 16'h0000, 16'hBEEF, 8);
    ramPeekAddr = RAM_AW'(7);
    #1;
    check(ramPeekData == 16'hBEEF, "R5 memory address wrap", int'(ramPeekData), 16'hBEEF);

    // R9: length field has no effect
    ramWr(16'h8009, 16'h7FFF, 16'h1357, 8);
    ramPeekAddr = RAM_AW'(9);
    #1;
    check(ramPeekData == 16'h1357, "R9 length ignored on write", int'(ramPeekData), 16'h1357);
    ramRd(16'h8009, 16'h0040);
    check({rxb[6], rxb[7]} == 16'h1357, "R9 length ignored on read", int'({rxb[6], rxb[7]}), 16'h1357);

    // R5: bit 15 clear, write ignored
    ramPeekAddr = RAM_AW'(51);
    #1;
    w = ramPeekData;
    ramWr(16'h0033, 16'h0000, 16'hDEAD, 8);
    #1;
    check(ramPeekData == w, "R5 bit15 clear ignored", int'(ramPeekData), int'(w));

    // R6: bit 15 clear, read returns zero
    ramRd(16'h0033, 16'h0001);
    check(rxb[6] == 0 && rxb[7] == 0, "R6 bit15 clear read zero", int'({rxb[6], rxb[7]}), 0);

    // R7: memory write aborted after seven bytes, then a clean frame
    ramPeekAddr = RAM_AW'(102);
    #1;
    w = ramPeekData;
    ramWr(16'h8066, 16'h0000, 16'hCAFE, 7);
    check(ramPeekData == w, "R7 aborted memory write", int'(ramPeekData), int'(w));
    regWr(8'h0A, 8'h5E, 4);
    regPeekAddr = 4'hA;
    #1;
    check(regPeekData == 8'h5E, "R7 frame after abort", int'(regPeekData), 8'h5E);

    prev = 8'h00;
    check(miso == 1'b0, "R7 miso idle after frame", int'(miso), int'(prev));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule